// File: doc/BRIEF.md
# Page-Mode DRAM Delay-Line Controller

This block sits between an audio delay-line engine and an external DRAM that has a 4-bit data bus and a 9-bit multiplexed address bus. A client presents one request at a time. Each request reads or writes a 16-bit word. The controller turns every request into a single page-mode burst: the row address is strobed once, then four column addresses follow. Each column address moves one nibble, so the four nibbles together form the word. The controller drives the active-low row strobe, column strobe, write enable and output enable. It also drives the address bus and an extra line that always carries the inverse of the top address bit.

A configuration input selects one of two memory geometries. The small geometry is a 256-kbit part that holds 16K words and never uses the top address line. The large geometry is a 1-Mbit part that holds 64K words. A free-running refresh timer raises a request at a programmable interval. The refresh is then run as a column-before-row cycle as soon as no burst is in progress. All timing is counted in whole cycles of the system clock.

Top module: `dline_dram_ctrl`

## Requirements
- R1: While reset is held, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is low, and `busy` and `rd_valid` are low.
- R2: Each accepted request produces exactly four column-strobe falls while the row strobe stays low. The column offsets are 0, 1, 2 and 3, in that order. The nibble at offset k is bits [15-4k:12-4k] of the word, so the most significant nibble goes first.
- R3: With `cfg_big`=1, the row address is word[15:7] and the column for offset k is word[6:0]*4+k.
- R4: With `cfg_big`=0, the row address is {0, word[13:6]} and the column is {0, word[5:0]}*4+k. Address line 8 stays 0, and word bits 15:14 have no effect, so word 0xC000|a reaches the same cells as a.
- R5: `dram_addr_msb_n` is the inverse of `dram_addr[8]` whenever a column strobe falls.
- R6: In a write burst, write enable is already low in the cycle before each column-strobe fall and stays low through it. During the burst `dram_dq_oe` is high and output enable is high.
- R7: In a read burst, output enable is low and write enable is high. Each nibble is sampled on the last clock edge before its column strobe rises. `rd_valid` pulses for one cycle with the word assembled most significant nibble first, 16 cycles after the accepting edge.
- R8: The first column-strobe fall of a burst comes T_RCD+1 = 3 cycles after the row-strobe fall.
- R9: `busy` goes high on the accepting edge and stays high until T_RP = 3 cycles after the row strobe rises. A request raised while `busy` is high is ignored.
- R10: With a non-zero `cfg_ref_interval`, a refresh is requested once per interval. Refresh drops the column strobe one cycle before the row strobe, with write enable high. When the controller is idle, successive refreshes are exactly one interval apart. A pending refresh waits until the current burst has finished its precharge.
- R11: A `cfg_ref_interval` of 0 stops refresh entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_big | input | 1 | 1 selects the 1-Mbit geometry, 0 the 256-kbit geometry; latched when a request is accepted |
| cfg_ref_interval | input | 16 | Refresh period in clock cycles; 0 disables refresh |
| req_valid | input | 1 | Request strobe, accepted on an edge where `busy` is low |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | High while a burst, a refresh or a pending refresh blocks new requests |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 16 | Assembled read word |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_addr_msb_n | output | 1 | Inverse of `dram_addr[8]` |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Nibble driven toward the memory |
| dram_dq_oe | output | 1 | High when the controller drives the data bus |
| dram_dq_in | input | 4 | Nibble returned by the memory |

## Verification
A request counts as accepted on the edge where `req_valid` is high and `busy` was low, and every expected time is counted from that edge. The row strobe falls 2 cycles after acceptance. The first column strobe falls 3 cycles after that, and each later nibble follows 3 cycles after the previous one. Read data is valid 16 cycles after acceptance, and `busy` drops 3 cycles after the row strobe rises. The bench samples every port on falling clock edges and runs a memory model that reacts to strobe edges. It compares row, column and nibble values at each strobe fall, and it checks read latency, busy release and refresh spacing as exact cycle differences. These exact-cycle checks run only with refresh off or while the controller is idle, so that a refresh cannot shift the result.

// File: rtl/dline_pkg.sv
`timescale 1ns/1ps
package dline_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_CSET,
        ST_CAS,
        ST_PRE,
        ST_RFC,
        ST_RFR
    } burst_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } dram_ctl_t;

    function automatic int dl_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int dl_tmr_width(input int a, input int b,
                                        input int c, input int d);
        int m;
        m = dl_max2(dl_max2(a, b), dl_max2(c, d));
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/dline_refresh_timer.sv
`timescale 1ns/1ps
module dline_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] interval,
    input  logic             ack,
    output logic             due
);

    logic [REF_W-1:0] cnt;
    logic             wrap;

    always_comb begin
        wrap = (interval != '0) && (cnt >= interval - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            if (interval == '0 || wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (wrap) begin
                due <= 1'b1;
            end else if (ack) begin
                due <= 1'b0;
            end
        end
    end

    // R11: with refresh switched off, no new request can appear
    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        (interval == '0 && !due) |=> !due);

endmodule

// File: rtl/dline_addr_map.sv
`timescale 1ns/1ps
module dline_addr_map #(
    parameter int WORD_AW = 16,
    parameter int ADDR_W  = 9,
    parameter int OFF_W   = 2
) (
    input  logic [WORD_AW-1:0] word,
    input  logic [OFF_W-1:0]   off,
    input  logic               big,
    output logic [ADDR_W-1:0]  row,
    output logic [ADDR_W-1:0]  col
);

    localparam int COLW_BIG = ADDR_W - OFF_W;
    localparam int COLW_SM  = ADDR_W - 1 - OFF_W;
    localparam int ROWW_SM  = ADDR_W - 1;

    logic [ADDR_W-1:0] row_big, col_big, row_sm, col_sm;

    always_comb begin
        row_big = word[WORD_AW-1:COLW_BIG];
        col_big = {word[COLW_BIG-1:0], off};
        row_sm  = {1'b0, word[COLW_SM+ROWW_SM-1:COLW_SM]};
        col_sm  = {1'b0, word[COLW_SM-1:0], off};
        row     = big ? row_big : row_sm;
        col     = big ? col_big : col_sm;
    end

endmodule

// File: rtl/dline_nibble_io.sv
`timescale 1ns/1ps
module dline_nibble_io #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  nib,
    input  logic              cap,
    input  logic              cap_last,
    input  logic [NIB_W-1:0]  dq_in,
    output logic [NIB_W-1:0]  dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NIBS = DATA_W / NIB_W;

    logic [DATA_W-1:0]       wdata_q;
    logic [DATA_W-NIB_W-1:0] shift_q;

    always_comb begin
        dq_out = wdata_q[(NIBS - 1 - int'(nib)) * NIB_W +: NIB_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q  <= '0;
            shift_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (load) begin
                wdata_q <= wdata;
            end
            if (cap) begin
                shift_q <= {shift_q[DATA_W-2*NIB_W-1:0], dq_in};
            end
            rd_valid <= cap && cap_last;
            if (cap && cap_last) begin
                rd_data <= {shift_q, dq_in};
            end
        end
    end

    // R7: read completion is a single-cycle pulse
    a_r7_one_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/dline_burst_fsm.sv
`timescale 1ns/1ps
module dline_burst_fsm
    import dline_pkg::*;
#(
    parameter int WORD_AW   = 16,
    parameter int ADDR_W    = 9,
    parameter int NIBS      = 4,
    parameter int OFF_W     = 2,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_due,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic               cfg_big,
    input  logic [ADDR_W-1:0]  row,
    input  logic [ADDR_W-1:0]  col,
    output logic               ref_ack,
    output logic               accept,
    output logic               busy,
    output logic               op_big,
    output logic [WORD_AW-1:0] op_word,
    output logic [OFF_W-1:0]   nib,
    output logic               cap,
    output logic               cap_last,
    output logic [ADDR_W-1:0]  dram_addr,
    output dram_ctl_t          ctl
);

    localparam int TMR_W = dl_tmr_width(T_RCD, T_CAS, T_RP, T_REF_RAS);

    burst_st_e        st;
    logic [TMR_W-1:0] tmr;
    logic             op_write;
    logic             tmr_done;
    logic             in_col;

    always_comb begin
        tmr_done = (tmr == '0);
        ref_ack  = (st == ST_IDLE) && ref_due;
        accept   = (st == ST_IDLE) && !ref_due && req_valid;
        busy     = (st != ST_IDLE) || ref_due;
        in_col   = (st == ST_CSET) || (st == ST_CAS);
        cap      = (st == ST_CAS) && tmr_done && !op_write;
        cap_last = (nib == OFF_W'(NIBS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            nib      <= '0;
            op_write <= 1'b0;
            op_big   <= 1'b0;
            op_word  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (ref_due) begin
                        st <= ST_RFC;
                    end else if (req_valid) begin
                        st       <= ST_ROW;
                        op_write <= req_write;
                        op_big   <= cfg_big;
                        op_word  <= req_addr;
                    end
                end
                ST_ROW: begin
                    st  <= ST_RCD;
                    tmr <= TMR_W'(T_RCD - 1);
                end
                ST_RCD: begin
                    if (tmr_done) begin
                        st  <= ST_CSET;
                        nib <= '0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_CSET: begin
                    st  <= ST_CAS;
                    tmr <= TMR_W'(T_CAS - 1);
                end
                ST_CAS: begin
                    if (tmr_done) begin
                        if (cap_last) begin
                            st  <= ST_PRE;
                            tmr <= TMR_W'(T_RP - 1);
                        end else begin
                            st  <= ST_CSET;
                            nib <= nib + 1'b1;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (tmr_done) begin
                        st <= ST_IDLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_RFC: begin
                    st  <= ST_RFR;
                    tmr <= TMR_W'(T_REF_RAS - 1);
                end
                ST_RFR: begin
                    if (tmr_done) begin
                        st  <= ST_PRE;
                        tmr <= TMR_W'(T_RP - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.ras_n = !((st == ST_RCD) || in_col || (st == ST_RFR));
        ctl.cas_n = !((st == ST_CAS) || (st == ST_RFC) || (st == ST_RFR));
        ctl.we_n  = !(op_write && in_col);
        ctl.oe_n  = !(!op_write && ((st == ST_RCD) || in_col));
        ctl.dq_oe = op_write && in_col;
        if ((st == ST_ROW) || (st == ST_RCD)) begin
            dram_addr = row;
        end else if (in_col) begin
            dram_addr = col;
        end else begin
            dram_addr = '0;
        end
    end

    // R6: write enable has settled before a column strobe falls
    a_r6_we_settled: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl.cas_n) && !ctl.ras_n) |-> $stable(ctl.we_n));

    // R6: controller never drives the bus while the memory drives it
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(ctl.dq_oe && !ctl.oe_n));

    // R10: a refresh row strobe only follows an already low column strobe
    a_r10_cbr_order: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl.ras_n) && !ctl.cas_n) |-> $past(!ctl.cas_n));

    // R2: the address holds while a column strobe stays low
    a_r2_col_stable: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cas_n && $past(!ctl.cas_n)) |-> $stable(dram_addr));

    // R9: the precharge after a burst is still reported as busy
    a_r9_busy_in_precharge: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.ras_n) |-> busy);

endmodule

// File: rtl/dline_dram_ctrl.sv
`timescale 1ns/1ps
module dline_dram_ctrl
    import dline_pkg::*;
#(
    parameter int WORD_AW   = 16,
    parameter int DATA_W    = 16,
    parameter int NIB_W     = 4,
    parameter int ADDR_W    = 9,
    parameter int REF_W     = 16,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_big,
    input  logic [REF_W-1:0]   cfg_ref_interval,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  dram_addr,
    output logic               dram_addr_msb_n,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_oe_n,
    output logic [NIB_W-1:0]   dram_dq_out,
    output logic               dram_dq_oe,
    input  logic [NIB_W-1:0]   dram_dq_in
);

    localparam int NIBS  = DATA_W / NIB_W;
    localparam int OFF_W = $clog2(NIBS);

    logic               ref_due, ref_ack, accept;
    logic               op_big, cap, cap_last;
    logic [WORD_AW-1:0] op_word;
    logic [OFF_W-1:0]   nib;
    logic [ADDR_W-1:0]  row, col;
    dram_ctl_t          ctl;

    dline_refresh_timer #(.REF_W(REF_W)) refresh_i (
        .clk      (clk),
        .rst      (rst),
        .interval (cfg_ref_interval),
        .ack      (ref_ack),
        .due      (ref_due)
    );

    dline_addr_map #(.WORD_AW(WORD_AW), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) map_i (
        .word (op_word),
        .off  (nib),
        .big  (op_big),
        .row  (row),
        .col  (col)
    );

    dline_burst_fsm #(
        .WORD_AW(WORD_AW), .ADDR_W(ADDR_W), .NIBS(NIBS), .OFF_W(OFF_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .ref_due   (ref_due),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cfg_big   (cfg_big),
        .row       (row),
        .col       (col),
        .ref_ack   (ref_ack),
        .accept    (accept),
        .busy      (busy),
        .op_big    (op_big),
        .op_word   (op_word),
        .nib       (nib),
        .cap       (cap),
        .cap_last  (cap_last),
        .dram_addr (dram_addr),
        .ctl       (ctl)
    );

    dline_nibble_io #(.DATA_W(DATA_W), .NIB_W(NIB_W), .OFF_W(OFF_W)) nio_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .wdata    (req_wdata),
        .nib      (nib),
        .cap      (cap),
        .cap_last (cap_last),
        .dq_in    (dram_dq_in),
        .dq_out   (dram_dq_out),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_comb begin
        dram_ras_n      = ctl.ras_n;
        dram_cas_n      = ctl.cas_n;
        dram_we_n       = ctl.we_n;
        dram_oe_n       = ctl.oe_n;
        dram_dq_oe      = ctl.dq_oe;
        dram_addr_msb_n = ~dram_addr[ADDR_W-1];
    end

endmodule

// File: tb/dline_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module dline_dram_ctrl_tb_top;

    localparam int LAT_RD    = 16;
    localparam int RAS2CAS   = 3;
    localparam int PRECHARGE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_big = 1'b1;
    logic [15:0] cfg_ref_interval = 16'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rd_valid;
    logic [15:0] rd_data;
    logic [8:0]  dram_addr;
    logic        dram_addr_msb_n, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [3:0]  dram_dq_in = '0;

    dline_dram_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_big(cfg_big), .cfg_ref_interval(cfg_ref_interval),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_addr_msb_n(dram_addr_msb_n),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    always #10 clk = ~clk;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] expv);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", rq, act, expv, $time);
        end
    endtask

    // expected operation, set by the stimulus
    bit          exp_write = 1'b0;
    bit          exp_big = 1'b1;
    logic [15:0] exp_word = '0;
    logic [15:0] exp_data = '0;

    // memory model and monitor state
    logic [3:0] mem [int unsigned];
    bit   prev_ras = 1'b1, prev_cas = 1'b1;
    bit   in_burst = 1'b0, first_cas = 1'b0;
    int   nib_seen = 0, burst_cnt = 0, ref_cnt = 0;
    int   ras_fall_cyc = 0, ras_rise_cyc = 0, last_ref_cyc = 0;
    bit   spacing_en = 1'b0, last_ref_ok = 1'b0;
    logic [8:0] row_lat = '0;

    function automatic int exp_row(input logic [15:0] w, input bit big);
        return big ? int'(w) / 128 : (int'(w) / 64) % 256;
    endfunction

    function automatic int exp_col(input logic [15:0] w, input bit big, input int k);
        return big ? (int'(w) % 128) * 4 + k : (int'(w) % 64) * 4 + k;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            bit ras_f, cas_f, ras_r;
            string rmap;
            ras_f = prev_ras && !dram_ras_n;
            cas_f = prev_cas && !dram_cas_n;
            ras_r = !prev_ras && dram_ras_n;
            rmap  = exp_big ? "R3" : "R4";
            if (cas_f && dram_ras_n) begin
                chk(dram_we_n == 1'b1, "R10 refresh we_n", {31'd0, dram_we_n}, 1);
                chk(!in_burst, "R10 refresh inside burst", {31'd0, in_burst}, 0);
            end
            if (ras_f && !dram_cas_n) begin
                ref_cnt++;
                if (spacing_en && last_ref_ok)
                    chk(cyc - last_ref_cyc == int'(cfg_ref_interval), "R10 spacing",
                        cyc - last_ref_cyc, cfg_ref_interval);
                last_ref_cyc = cyc;
                last_ref_ok  = 1'b1;
            end
            if (ras_f && dram_cas_n) begin
                in_burst = 1'b1;
                first_cas = 1'b1;
                nib_seen = 0;
                row_lat = dram_addr;
                burst_cnt++;
                ras_fall_cyc = cyc;
                chk(int'(dram_addr) == exp_row(exp_word, exp_big), {rmap, " row"},
                    dram_addr, exp_row(exp_word, exp_big));
            end
            if (cas_f && !dram_ras_n) begin
                int unsigned key;
                logic [3:0] en;
                if (first_cas)
                    chk(cyc - ras_fall_cyc == RAS2CAS, "R8 ras-to-cas",
                        cyc - ras_fall_cyc, RAS2CAS);
                first_cas = 1'b0;
                chk(int'(dram_addr) == exp_col(exp_word, exp_big, nib_seen),
                    {rmap, " col"}, dram_addr, exp_col(exp_word, exp_big, nib_seen));
                chk(dram_addr_msb_n == ~dram_addr[8], "R5 msb inverse",
                    {31'd0, dram_addr_msb_n}, {31'd0, ~dram_addr[8]});
                key = {14'd0, row_lat, dram_addr};
                en = exp_data[15 - 4*nib_seen -: 4];
                if (exp_write) begin
                    chk(!dram_we_n && dram_oe_n && dram_dq_oe, "R6 write strobes",
                        {29'd0, dram_we_n, dram_oe_n, dram_dq_oe}, 3'b011);
                    chk(dram_dq_out == en, "R2 nibble order", dram_dq_out, en);
                    mem[key] = dram_dq_out;
                end else begin
                    chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R7 read strobes",
                        {29'd0, dram_we_n, dram_oe_n, dram_dq_oe}, 3'b100);
                    dram_dq_in = mem.exists(key) ? mem[key] : 4'h0;
                end
                nib_seen++;
            end
            if (ras_r) begin
                ras_rise_cyc = cyc;
                if (in_burst) chk(nib_seen == 4, "R2 nibbles per burst", nib_seen, 4);
                in_burst = 1'b0;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_req(input bit w, input logic [15:0] word, input logic [15:0] data,
                          input bit big, output int lat);
        wait_idle();
        exp_write = w; exp_word = word; exp_data = data; exp_big = big;
        cfg_big = big; req_write = w; req_addr = word; req_wdata = data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (!w) begin
            while (!rd_valid && lat < 200) begin
                @(negedge clk);
                lat++;
            end
        end
    endtask

    function automatic logic [15:0] pat(input logic [15:0] a, input bit big);
        logic [15:0] m;
        m = big ? a : (a & 16'h3FFF);
        return (m ^ 16'h9C3E) + {m[7:0], m[15:8]};
    endfunction

    initial begin
        int lat, b0, r0;
        logic [15:0] alist [10];
        alist = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h003F,
                  16'h0040, 16'h3FFF, 16'hFFFF, 16'h5A5A, 16'hA5A5};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes",
            {28'd0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dram_dq_oe && !busy && !rd_valid, "R1 outputs",
            {29'd0, dram_dq_oe, busy, rd_valid}, 0);
        rst = 1'b0;

        // R7 latency and data, refresh off
        do_req(1'b1, 16'h1234, 16'hBEEF, 1'b1, lat);
        do_req(1'b0, 16'h1234, 16'h0000, 1'b1, lat);
        chk(lat == LAT_RD, "R7 read latency", lat, LAT_RD);
        chk(rd_data == 16'hBEEF, "R7 read data", rd_data, 16'hBEEF);
        @(negedge clk);
        chk(!rd_valid, "R7 single pulse", {31'd0, rd_valid}, 0);

        // R9 busy hold-off and release
        wait_idle();
        b0 = burst_cnt;
        exp_write = 1'b1; exp_word = 16'h0246; exp_data = 16'h1357; exp_big = 1'b1;
        cfg_big = 1'b1; req_write = 1'b1; req_addr = 16'h0246; req_wdata = 16'h1357;
        req_valid = 1'b1;
        @(negedge clk);
        chk(busy, "R9 busy after accept", {31'd0, busy}, 1);
        req_addr = 16'h0F0F; req_wdata = 16'hFFFF;
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        chk(cyc - ras_rise_cyc == PRECHARGE, "R9 busy release", cyc - ras_rise_cyc, PRECHARGE);
        repeat (5) @(negedge clk);
        chk(burst_cnt - b0 == 1, "R9 ignored request", burst_cnt - b0, 1);

        // R10 refresh spacing while idle
        cfg_ref_interval = 16'd40;
        spacing_en = 1'b1; last_ref_ok = 1'b0;
        r0 = ref_cnt;
        repeat (400) @(negedge clk);
        spacing_en = 1'b0;
        chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 10, "R10 refresh count", ref_cnt - r0, 10);

        // R11 refresh off
        cfg_ref_interval = 16'd0;
        repeat (20) @(negedge clk);
        r0 = ref_cnt;
        repeat (300) @(negedge clk);
        chk(ref_cnt == r0, "R11 no refresh", ref_cnt - r0, 0);

        // sweep both geometries with refresh interleaved
        cfg_ref_interval = 16'd37;
        for (int g = 1; g >= 0; g--) begin
            for (int i = 0; i < 26; i++) begin
                logic [15:0] a;
                a = (i < 10) ? alist[i] : 16'(16'h1111 * (i - 10));
                do_req(1'b1, a, pat(a, g[0]), g[0], lat);
            end
            for (int i = 0; i < 26; i++) begin
                logic [15:0] a;
                a = (i < 10) ? alist[i] : 16'(16'h1111 * (i - 10));
                do_req(1'b0, a, pat(a, g[0]), g[0], lat);
                chk(rd_data == pat(a, g[0]), g[0] ? "R3 readback" : "R4 readback",
                    rd_data, pat(a, g[0]));
            end
        end

        // R4 upper word bits ignored in the small geometry
        do_req(1'b1, 16'h0123, 16'hC0DE, 1'b0, lat);
        do_req(1'b0, 16'hC123, 16'hC0DE, 1'b0, lat);
        chk(rd_data == 16'hC0DE, "R4 alias", rd_data, 16'hC0DE);

        wait_idle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            vecs++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule